// File: doc/BRIEF.md
# Paged Nonvolatile Write Controller

This block gives a byte-wide memory with asynchronous, active-low select, read-enable and write-enable strobes the write behaviour of a paged nonvolatile part. A host writes a byte by pulling select and write-enable low together while read-enable is high. The byte does not go straight into storage. It goes into a page buffer, and further bytes aimed at the same page may follow. When no new byte arrives for a configurable number of clock cycles, loading closes and a self-timed program cycle starts. At the end of that cycle the buffered bytes are copied into the storage array.

During the program cycle, a host can tell whether the cycle has finished without a ready pin. Any read returns bit 7 inverted relative to the last byte loaded, and bit 6 flips on every read. When the program cycle ends, reads return the stored contents again. The strobes are synchronised to the system clock and edge-detected. The storage array is a register model whose size comes from the address width parameter.

The data bus is split into an input and an output. `dataOe` marks when the block would drive the bus, and `dataOut` is held at zero while `dataOe` is low. In the port table, the page number is the address above the low `PAGE_BITS` bits, and the offset is those low bits.

Top module: `nvw_page_writer`

## Requirements
- R1: After reset, `busy`, `pageErr` and `dataOe` are 0, and every array location reads 8'hFF.
- R2: A write happens only while select and write-enable are both low and read-enable is high. The address is taken when that condition starts, and the data is taken when it ends. Holding all three strobes low writes nothing.
- R3: The first byte opens a load. Each later byte restarts a window of `LOAD_WINDOW` cycles. When the window expires with no new byte, the program cycle begins and `busy` goes to 1.
- R4: A byte whose page number differs from the page of the first byte in the load is discarded and sets `pageErr`. `pageErr` then stays 1 until reset.
- R5: Only the offsets loaded during the load are changed in the array. Loading the same offset twice keeps the later byte.
- R6: `busy` stays high for exactly `PROG_CYCLES` cycles, and write strobes during that time are ignored. After it falls, reads return the programmed data.
- R7: While `busy` is 1, any read shows bit 7 as the complement of bit 7 of the last byte loaded.
- R8: While `busy` is 1, bit 6 of the read data is a status bit. It is cleared when programming starts and flips on each new read, so the first read shows 1, the next 0, and so on.
- R9: `dataOe` is 1 only while select and read-enable are low and write-enable is high. When `dataOe` is 0, `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addr | input | ADDR_W | Byte address: page number in the upper bits, offset in the low PAGE_BITS bits |
| dataIn | input | DATA_W | Write data bus |
| ceN | input | 1 | Active-low select |
| oeN | input | 1 | Active-low read enable |
| weN | input | 1 | Active-low write enable |
| dataOut | output | DATA_W | Read data; 0 when not driving |
| dataOe | output | 1 | High when the read data is being driven |
| busy | output | 1 | Program cycle in progress |
| pageErr | output | 1 | Sticky flag: a byte for the wrong page was discarded |

## Verification
Each strobe passes through a two-stage synchroniser and an edge-detect register. A write or read condition therefore takes effect three clocks after the pins change. The bench holds every strobe level for at least four clocks and samples outputs on falling edges, five clocks into each read. `busy` rises `LOAD_WINDOW` cycles after the last byte is accepted, and falls `PROG_CYCLES` cycles after that. To stay clear of both edges, the checks test `busy` at points roughly ten cycles before or after each expected change. Array contents are checked only after `busy` has fallen.

// File: rtl/nvw_pkg.sv
package nvw_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LOAD, ST_PROG} nvwState_t;

  typedef struct packed {
    logic latchAddr;   // write condition began: capture address
    logic loadFirst;   // first byte of a load
    logic loadByte;    // further byte of the same page
    logic startProg;   // load closed, program cycle begins
    logic commit;      // last program cycle: copy buffer to array
    logic flipToggle;  // new read while busy
  } nvwCtl_t;
endpackage

// File: rtl/nvw_control.sv
module nvw_control
  import nvw_pkg::*;
#(
  parameter int LOAD_WINDOW = 15000,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    ceN,
  input  logic    oeN,
  input  logic    weN,
  input  logic    pageMatch,
  output nvwCtl_t ctl,
  output logic    readAct,
  output logic    busy,
  output logic    pageErr
);
  localparam int TW = $clog2(LOAD_WINDOW + 1);
  localparam int PW = $clog2(PROG_CYCLES + 1);
  localparam logic [TW-1:0] WIN_LAST  = TW'(LOAD_WINDOW - 1);
  localparam logic [PW-1:0] PROG_LAST = PW'(PROG_CYCLES - 1);

  // {ce, oe, we} through two sync stages
  logic [2:0] syncA, syncB;
  logic       writeAct, writeActQ, readActQ;
  logic       writeStart, writeEnd, readStart;
  nvwState_t  state;
  logic [TW-1:0] winCnt;
  logic [PW-1:0] progCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 3'b111;
      syncB <= 3'b111;
      writeActQ <= 1'b0;
      readActQ  <= 1'b0;
    end else begin
      syncA <= {ceN, oeN, weN};
      syncB <= syncA;
      writeActQ <= writeAct;
      readActQ  <= readAct;
    end
  end

  assign writeAct   = !syncB[2] && syncB[1] && !syncB[0];
  assign readAct    = !syncB[2] && !syncB[1] && syncB[0];
  assign writeStart = writeAct && !writeActQ;
  assign writeEnd   = !writeAct && writeActQ;
  assign readStart  = readAct && !readActQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      progCnt <= '0;
      pageErr <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          winCnt <= '0;
          if (writeEnd) state <= ST_LOAD;
        end
        ST_LOAD: begin
          if (writeEnd && pageMatch) begin
            winCnt <= '0;
          end else if (winCnt == WIN_LAST) begin
            state   <= ST_PROG;
            progCnt <= '0;
          end else begin
            winCnt <= winCnt + 1'b1;
          end
          if (writeEnd && !pageMatch) pageErr <= 1'b1;
        end
        default: begin
          if (progCnt == PROG_LAST) state <= ST_IDLE;
          else progCnt <= progCnt + 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    ctl            = '0;
    ctl.latchAddr  = writeStart && (state != ST_PROG);
    ctl.loadFirst  = writeEnd && (state == ST_IDLE);
    ctl.loadByte   = writeEnd && (state == ST_LOAD) && pageMatch;
    ctl.startProg  = (state == ST_LOAD) && !(writeEnd && pageMatch) && (winCnt == WIN_LAST);
    ctl.commit     = (state == ST_PROG) && (progCnt == PROG_LAST);
    ctl.flipToggle = readStart && (state == ST_PROG);
  end

  assign busy = (state == ST_PROG);
endmodule

// File: rtl/nvw_datapath.sv
module nvw_datapath
  import nvw_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  nvwCtl_t           ctl,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              busy,
  input  logic              readAct,
  output logic              pageMatch,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PN_W      = ADDR_W - PAGE_BITS;

  logic [ADDR_W-1:0] addrLat;
  logic [PN_W-1:0]   pageReg;
  logic [DATA_W-1:0] lastData;
  logic              toggle;
  logic [DATA_W-1:0] slotData [PAGE_SIZE];
  logic [PAGE_SIZE-1:0] slotValid;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [PAGE_BITS-1:0] offLat;

  assign offLat    = addrLat[PAGE_BITS-1:0];
  assign pageMatch = (addrLat[ADDR_W-1:PAGE_BITS] == pageReg);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLat  <= '0;
      pageReg  <= '0;
      lastData <= '0;
      toggle   <= 1'b0;
    end else begin
      if (ctl.latchAddr) addrLat <= addr;
      if (ctl.loadFirst) pageReg <= addrLat[ADDR_W-1:PAGE_BITS];
      if (ctl.loadFirst || ctl.loadByte) lastData <= dataIn;
      if (ctl.startProg) toggle <= 1'b0;
      else if (ctl.flipToggle) toggle <= ~toggle;
    end
  end

  for (genvar g = 0; g < PAGE_SIZE; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotValid[g] <= 1'b0;
        slotData[g]  <= '0;
      end else if ((ctl.loadFirst || ctl.loadByte) && offLat == PAGE_BITS'(g)) begin
        slotValid[g] <= 1'b1;
        slotData[g]  <= dataIn;
      end else if (ctl.loadFirst) begin
        slotValid[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (ctl.commit) begin
      for (int i = 0; i < PAGE_SIZE; i++)
        if (slotValid[i]) mem[{pageReg, PAGE_BITS'(i)}] <= slotData[i];
    end
  end

  assign dataOe = readAct;

  always_comb begin
    if (!readAct)  dataOut = '0;
    else if (busy) dataOut = {~lastData[DATA_W-1], toggle, lastData[DATA_W-3:0]};
    else           dataOut = mem[addr];
  end
endmodule

// File: rtl/nvw_page_writer.sv
module nvw_page_writer
  import nvw_pkg::*;
#(
  parameter int ADDR_W      = 10,
  parameter int DATA_W      = 8,
  parameter int PAGE_BITS   = 6,
  parameter int LOAD_WINDOW = 15000,
  parameter int PROG_CYCLES = 1000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busy,
  output logic              pageErr
);
  nvwCtl_t ctl;
  logic    pageMatch;
  logic    readAct;

  nvw_control #(.LOAD_WINDOW(LOAD_WINDOW), .PROG_CYCLES(PROG_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .pageMatch(pageMatch), .ctl(ctl), .readAct(readAct),
    .busy(busy), .pageErr(pageErr)
  );

  nvw_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .addr(addr), .dataIn(dataIn),
    .busy(busy), .readAct(readAct), .pageMatch(pageMatch),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: rtl/nvw_checker.sv
module nvw_checker #(
  parameter int DATA_W      = 8,
  parameter int PROG_CYCLES = 1000000
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              pageErr,
  input logic              dataOe,
  input logic [DATA_W-1:0] dataOut
);
  logic [31:0] busyLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) busyLen <= '0;
    else busyLen <= busy ? busyLen + 1 : '0;
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    pageErr |=> pageErr); // R4

  AST_QUIET_BUS: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0)); // R9

  AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (busyLen < PROG_CYCLES)); // R6

  AST_BUSY_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (busyLen == PROG_CYCLES)); // R6

  AST_POLL_BIT7_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && dataOe && $past(dataOe)) |-> $stable(dataOut[DATA_W-1])); // R7
endmodule

bind nvw_page_writer nvw_checker #(.DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)) u_chk (.*);

// File: tb/nvw_page_writer_tb.sv
module nvw_page_writer_tb;
  localparam int AW = 10;
  localparam int WIN = 40;
  localparam int PROG = 100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] dataIn = '0;
  logic ceN = 1'b1, oeN = 1'b1, weN = 1'b1;
  logic [7:0] dataOut;
  logic dataOe, busy, pageErr;
  int vecs = 0;
  int errs = 0;

  always #5 clk = ~clk;

  nvw_page_writer #(.ADDR_W(AW), .DATA_W(8), .PAGE_BITS(6),
                    .LOAD_WINDOW(WIN), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rstN(rstN), .addr(addr), .dataIn(dataIn), .ceN(ceN),
    .oeN(oeN), .weN(weN), .dataOut(dataOut), .dataOe(dataOe),
    .busy(busy), .pageErr(pageErr)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrByte(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 1'b0; weN = 1'b0;
    idle(4);
    weN = 1'b1;
    idle(2);
    ceN = 1'b1;
    idle(3);
  endtask

  task automatic rdByte(input logic [AW-1:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk);
    addr = a; ceN = 1'b0; oeN = 1'b0;
    idle(5);
    v = dataOut; oe = dataOe;
    ceN = 1'b1; oeN = 1'b1;
    idle(4);
  endtask

  task automatic expectRead(input string req, input logic [AW-1:0] a, input logic [7:0] exp);
    logic [7:0] v; logic oe;
    rdByte(a, v, oe);
    chk(req, {23'd0, oe, v}, {23'd0, 1'b1, exp});
  endtask

  // R1: reset values
  task automatic tReset();
    chk("R1 busy", busy, 0);
    chk("R1 pageErr", pageErr, 0);
    chk("R9 dataOe idle", dataOe, 0);
    expectRead("R1 erased", 10'h005, 8'hFF);
  endtask

  // R3 R5 R6 R7 R8: page load, polling, commit
  task automatic tPageLoad();
    logic [7:0] v1, v2; logic oe;
    wrByte(10'h0CA, 8'h5A);
    wrByte(10'h0C2, 8'h81);
    wrByte(10'h0CA, 8'h3C);
    idle(20);
    chk("R3 open window", busy, 0);
    idle(30);
    chk("R3 program started", busy, 1);
    rdByte(10'h000, v1, oe);
    chk("R7 bit7 inverted", v1[7], 1);
    chk("R8 first read bit6", v1[6], 1);
    rdByte(10'h3FF, v2, oe);
    chk("R8 second read bit6", v2[6], 0);
    chk("R7 bit7 again", v2[7], 1);
    wrByte(10'h0D4, 8'h11);
    idle(80);
    chk("R6 busy ended", busy, 0);
    expectRead("R5 overwrite", 10'h0CA, 8'h3C);
    expectRead("R5 second byte", 10'h0C2, 8'h81);
    expectRead("R5 unloaded", 10'h0CB, 8'hFF);
    expectRead("R6 write while busy", 10'h0D4, 8'hFF);
  endtask

  // R3: window expiry closes a one-byte load
  task automatic tTimeout();
    wrByte(10'h100, 8'h11);
    idle(50);
    chk("R3 timeout started", busy, 1);
    idle(110);
    chk("R6 done", busy, 0);
    wrByte(10'h104, 8'h22);
    idle(50);
    chk("R3 second load", busy, 1);
    idle(110);
    expectRead("R3 first load kept", 10'h100, 8'h11);
    expectRead("R3 second load data", 10'h104, 8'h22);
  endtask

  // R2: address at start, data at end; no write with read-enable low
  task automatic tCapture();
    @(negedge clk);
    addr = 10'h080; dataIn = 8'h01; ceN = 1'b0; weN = 1'b0;
    idle(4);
    addr = 10'h081; dataIn = 8'h77;
    idle(4);
    weN = 1'b1;
    idle(2);
    ceN = 1'b1;
    idle(160);
    expectRead("R2 data at end", 10'h080, 8'h77);
    expectRead("R2 addr at start", 10'h081, 8'hFF);
    @(negedge clk);
    addr = 10'h090; dataIn = 8'h00; ceN = 1'b0; weN = 1'b0; oeN = 1'b0;
    idle(5);
    chk("R9 no drive during write strobe", {23'd0, dataOe, dataOut}, 0);
    weN = 1'b1; oeN = 1'b1; ceN = 1'b1;
    idle(50);
    chk("R2 no load with oe low", busy, 0);
    expectRead("R2 location untouched", 10'h090, 8'hFF);
    @(negedge clk);
    oeN = 1'b0;
    idle(5);
    chk("R9 no drive without select", {23'd0, dataOe, dataOut}, 0);
    oeN = 1'b1;
    idle(3);
  endtask

  // R4: wrong-page byte dropped, flag sticky
  task automatic tPageErr();
    wrByte(10'h200, 8'h44);
    wrByte(10'h240, 8'h55);
    chk("R4 flag set", pageErr, 1);
    idle(160);
    expectRead("R4 first page kept", 10'h200, 8'h44);
    expectRead("R4 other page dropped", 10'h240, 8'hFF);
    chk("R4 flag sticky", pageErr, 1);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(3);
    tReset();
    tPageLoad();
    tTimeout();
    tCapture();
    tPageErr();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule